// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block connects a processor's load/store unit to a data memory that is 32 bits wide and addressed by word. For every request it forms the effective address as a base register plus a sign-extended 16-bit immediate. It returns the word address and uses the two low address bits to pick byte lanes. For a store it produces per-lane write strobes and write data in the lanes the memory expects. For a load it remembers how the request must be decoded, then extracts and extends the addressed byte, halfword or word when the memory word returns one cycle later.

Byte numbering inside a word is chosen per request. In little-endian order, offset 0 is the least significant byte. In big-endian order, offset 0 is the most significant byte. A halfword or word access whose address is not a multiple of its size is flagged as misaligned and produces no memory write and no load result. The store path and the lane decode are combinational. A single register stage carries the resolved load control from the request cycle to the data-return cycle.

Top module: `lsa_aligner`

## Requirements
- R1: `mem_addr` equals bits [31:2] of `base_addr` plus `imm_ofs` sign-extended to 32 bits, in the same cycle as the request.
- R2: With `req_valid` high, `misalign` is 1 for a halfword (size code 1) with address bit 0 set, and for a word (size code 2 or 3) with address bits [1:0] nonzero. A byte (size code 0) is never misaligned. `misalign` is 0 when `req_valid` is low.
- R3: For an aligned store, strobe bit n enables data bits [8n+7:8n]. A byte at offset k sets bit k when `req_big_endian`=0 and bit 3-k when it is 1. A halfword sets 4'b0011 or 4'b1100 for offsets 0 and 2 in little-endian order, and 4'b1100 or 4'b0011 for offsets 0 and 2 in big-endian order. A word sets 4'b1111.
- R4: For an aligned store, `mem_wdata` holds four copies of `st_data[7:0]` for a byte, two copies of `st_data[15:0]` for a halfword, and `st_data` for a word.
- R5: `mem_wstrb` is 4'b0000 for loads, for idle cycles and for misaligned stores.
- R6: An aligned load (`req_store`=0) raises `ld_valid` in the next cycle. In that cycle `ld_result` holds the addressed lanes of `mem_rdata`, picked with the lane mapping of R3.
- R7: With `req_zext`=0, a byte or halfword load copies the item's top bit into all upper result bits. With `req_zext`=1, the upper result bits are 0.
- R8: A misaligned load, a store or an idle cycle gives `ld_valid`=0 in the next cycle. `ld_result` is 0 whenever `ld_valid` is 0.
- R9: After reset, and before any request, `ld_valid` is 0, `ld_result` is 0 and `mem_wstrb` is 0.
- R10: A load is decoded with the size, offset, endianness and extension of its own request, whatever those inputs carry in the return cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_zext | input | 1 | Load extension: 1 zero, 0 sign |
| req_big_endian | input | 1 | 1 = offset 0 is the most significant byte |
| base_addr | input | 32 | Base register value |
| imm_ofs | input | 16 | Signed address displacement |
| st_data | input | 32 | Register value to store |
| mem_rdata | input | 32 | Memory word returned one cycle after a load |
| mem_addr | output | 30 | Word address to memory |
| mem_wstrb | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-placed write data |
| misalign | output | 1 | Request address not a multiple of its size |
| ld_valid | output | 1 | Load result valid this cycle |
| ld_result | output | 32 | Extended load value |

## Verification
The address, misalign flag, strobes and write data are combinational, so they are due in the request cycle itself. Load results are due exactly one clock later, in the cycle the memory word is presented. The bench drives each request on a falling edge and samples the store-side outputs 1 ns later in the same low phase. After the next rising edge it presents the read word, scrambles the request inputs, and samples `ld_valid` and `ld_result` 1 ns after that falling edge. Because the request inputs are scrambled before that sample, the check for R10 sees only the state that the register stage carried.

// File: rtl/lsa_pkg.sv
`timescale 1ns/1ps
package lsa_pkg;

    localparam int unsigned LANES  = 4;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned DATA_W = LANES * BYTE_W;
    localparam int unsigned OFS_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_size_e;

    // Resolved load decode carried to the data-return cycle
    typedef struct packed {
        logic             valid;
        logic [OFS_W:0]   nbytes;
        logic [OFS_W-1:0] shift;
        logic             zext;
    } ld_ctrl_t;

endpackage

// File: rtl/lsa_lane_map.sv
`timescale 1ns/1ps
module lsa_lane_map
    import lsa_pkg::*;
#(
    parameter int unsigned N_LANES = LANES,
    localparam int unsigned OW     = $clog2(N_LANES)
) (
    input  acc_size_e     size,
    input  logic [OW-1:0] ofs,
    input  logic          big_end,
    output logic [OW:0]   nbytes,
    output logic [OW-1:0] shift,
    output logic          misalign
);

    logic [OW-1:0] span_m1;
    logic [OW-1:0] aligned;
    logic [OW-1:0] rev_base;

    always_comb begin
        case (size)
            SZ_BYTE: nbytes = (OW+1)'(1);
            SZ_HALF: nbytes = (OW+1)'(2);
            default: nbytes = (OW+1)'(N_LANES);
        endcase
        span_m1  = OW'(nbytes - 1'b1);
        misalign = |(ofs & span_m1);
        aligned  = ofs & ~span_m1;
        // big-endian: lowest-numbered byte sits in the top lane
        rev_base = OW'((OW+1)'(N_LANES) - nbytes);
        shift    = big_end ? (rev_base - aligned) : aligned;
    end

endmodule

// File: rtl/lsa_store_lanes.sv
`timescale 1ns/1ps
module lsa_store_lanes
    import lsa_pkg::*;
#(
    parameter int unsigned N_LANES = LANES,
    localparam int unsigned OW     = $clog2(N_LANES),
    localparam int unsigned DW     = N_LANES * BYTE_W
) (
    input  logic               enable,
    input  logic [OW:0]        nbytes,
    input  logic [OW-1:0]      shift,
    input  logic [DW-1:0]      wr_src,
    output logic [N_LANES-1:0] strb,
    output logic [DW-1:0]      wdata
);

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [OW:0]   rel;
        logic [OW-1:0] src;
        logic          hit;
        logic [BYTE_W-1:0] lane_byte;

        always_comb begin
            rel       = (OW+1)'(i) - {1'b0, shift};
            hit       = ((OW+1)'(i) >= {1'b0, shift}) && (rel < nbytes);
            // replicate the low item across all lanes
            src       = OW'(i) & OW'(nbytes - 1'b1);
            lane_byte = wr_src[src*BYTE_W +: BYTE_W];
        end

        assign strb[i]                     = enable && hit;
        assign wdata[i*BYTE_W +: BYTE_W]   = lane_byte;
    end

endmodule

// File: rtl/lsa_load_lanes.sv
`timescale 1ns/1ps
module lsa_load_lanes
    import lsa_pkg::*;
#(
    parameter int unsigned N_LANES = LANES,
    localparam int unsigned OW     = $clog2(N_LANES),
    localparam int unsigned DW     = N_LANES * BYTE_W
) (
    input  logic [OW:0]   nbytes,
    input  logic [OW-1:0] shift,
    input  logic          zext,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] result
);

    logic [OW-1:0]     top_lane;
    logic              sign_bit;
    logic [BYTE_W-1:0] fill;

    always_comb begin
        top_lane = shift + OW'(nbytes - 1'b1);
        sign_bit = rd_word[top_lane*BYTE_W + BYTE_W - 1];
        fill     = zext ? '0 : {BYTE_W{sign_bit}};
    end

    for (genvar j = 0; j < N_LANES; j++) begin : g_res
        logic [OW-1:0]     lane;
        logic [BYTE_W-1:0] res_byte;

        always_comb begin
            lane     = shift + OW'(j);
            res_byte = ((OW+1)'(j) < nbytes) ? rd_word[lane*BYTE_W +: BYTE_W] : fill;
        end

        assign result[j*BYTE_W +: BYTE_W] = res_byte;
    end

endmodule

// File: rtl/lsa_aligner.sv
`timescale 1ns/1ps
module lsa_aligner
    import lsa_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [1:0]          req_size,
    input  logic                req_zext,
    input  logic                req_big_endian,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [IMM_W-1:0]    imm_ofs,
    input  logic [DATA_W-1:0]   st_data,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [ADDR_W-OFS_W-1:0] mem_addr,
    output logic [LANES-1:0]    mem_wstrb,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                misalign,
    output logic                ld_valid,
    output logic [DATA_W-1:0]   ld_result
);

    logic [ADDR_W-1:0] eff_addr;
    logic [OFS_W:0]    map_nbytes;
    logic [OFS_W-1:0]  map_shift;
    logic              map_mis;
    logic              st_go;
    logic [DATA_W-1:0] ld_raw;

    ld_ctrl_t ld_d, ld_q;

    always_comb begin
        eff_addr = base_addr + ADDR_W'({{(ADDR_W-IMM_W){imm_ofs[IMM_W-1]}}, imm_ofs});
    end

    assign mem_addr = eff_addr[ADDR_W-1:OFS_W];

    lsa_lane_map #(.N_LANES(LANES)) i_map (
        .size     (acc_size_e'(req_size)),
        .ofs      (eff_addr[OFS_W-1:0]),
        .big_end  (req_big_endian),
        .nbytes   (map_nbytes),
        .shift    (map_shift),
        .misalign (map_mis)
    );

    assign st_go    = req_valid && req_store && !map_mis;
    assign misalign = req_valid && map_mis;

    lsa_store_lanes #(.N_LANES(LANES)) i_st (
        .enable (st_go),
        .nbytes (map_nbytes),
        .shift  (map_shift),
        .wr_src (st_data),
        .strb   (mem_wstrb),
        .wdata  (mem_wdata)
    );

    always_comb begin
        ld_d       = ld_q;
        ld_d.valid = req_valid && !req_store && !map_mis;
        if (ld_d.valid) begin
            ld_d.nbytes = map_nbytes;
            ld_d.shift  = map_shift;
            ld_d.zext   = req_zext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_q <= '0;
        end else begin
            ld_q <= ld_d;
        end
    end

    lsa_load_lanes #(.N_LANES(LANES)) i_ld (
        .nbytes  (ld_q.nbytes),
        .shift   (ld_q.shift),
        .zext    (ld_q.zext),
        .rd_word (mem_rdata),
        .result  (ld_raw)
    );

    assign ld_valid  = ld_q.valid;
    assign ld_result = ld_q.valid ? ld_raw : '0;

endmodule

// File: rtl/lsa_aligner_chk.sv
`timescale 1ns/1ps
module lsa_aligner_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_store,
    input logic [1:0]  req_size,
    input logic [3:0]  mem_wstrb,
    input logic        misalign,
    input logic        ld_valid,
    input logic [31:0] ld_result
);

    AST_MIS_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> mem_wstrb == 4'b0000); // R5

    AST_LOAD_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_store) |-> mem_wstrb == 4'b0000); // R5

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd0) |-> $countones(mem_wstrb) == 1); // R3

    AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd1 && !misalign) |-> $countones(mem_wstrb) == 2); // R3

    AST_BYTE_NEVER_MIS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == 2'd0) |-> !misalign); // R2

    AST_LDV_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(req_valid && !req_store && !misalign)); // R6

    AST_LDV_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misalign) |=> !ld_valid); // R8

    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> ld_result == 32'd0); // R8

endmodule

bind lsa_aligner lsa_aligner_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_store (req_store),
    .req_size  (req_size),
    .mem_wstrb (mem_wstrb),
    .misalign  (misalign),
    .ld_valid  (ld_valid),
    .ld_result (ld_result)
);

// File: tb/test_lsa_aligner.sv
`timescale 1ns/1ps
module test_lsa_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_zext = 1'b0;
    logic        req_big_endian = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] imm_ofs = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_rdata = '0;
    logic [29:0] mem_addr;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_wdata;
    logic        misalign;
    logic        ld_valid;
    logic [31:0] ld_result;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lsa_aligner i_lsa_aligner (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_zext(req_zext), .req_big_endian(req_big_endian),
        .base_addr(base_addr), .imm_ofs(imm_ofs), .st_data(st_data),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
        .mem_wdata(mem_wdata), .misalign(misalign), .ld_valid(ld_valid),
        .ld_result(ld_result)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int nbytes_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic bit mis_of(input logic [1:0] sz, input logic [1:0] ofs);
        if (sz == 2'd0) return 1'b0;
        if (sz == 2'd1) return ofs[0];
        return ofs != 2'd0;
    endfunction

    // lowest physical lane holding the item
    function automatic int lane_of(input logic [1:0] sz, input logic [1:0] ofs, input logic be);
        int n = nbytes_of(sz);
        if (n == 4) return 0;
        if (!be) return int'(ofs);
        return 4 - n - int'(ofs);
    endfunction

    function automatic logic [3:0] exp_strb(input logic [1:0] sz, input logic [1:0] ofs, input logic be);
        int n = nbytes_of(sz);
        int l = lane_of(sz, ofs, be);
        if (n == 4) return 4'b1111;
        if (n == 2) return 4'(3 << l);
        return 4'(1 << l);
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'd0) return {4{d[7:0]}};
        if (sz == 2'd1) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] exp_load(input logic [1:0] sz, input logic [1:0] ofs,
                                             input logic be, input logic zx, input logic [31:0] rd);
        int l = lane_of(sz, ofs, be);
        logic [31:0] sh = rd >> (8 * l);
        if (sz == 2'd0) return zx ? {24'd0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
        if (sz == 2'd1) return zx ? {16'd0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
        return rd;
    endfunction

    task automatic run_op(input logic st, input logic [1:0] sz, input logic zx, input logic be,
                          input logic [31:0] base, input logic [15:0] imm,
                          input logic [31:0] sd, input logic [31:0] rd);
        logic [31:0] ea;
        logic        mis;
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_zext = zx;
        req_big_endian = be; base_addr = base; imm_ofs = imm; st_data = sd;
        mem_rdata = $urandom;
        #1;
        ea  = base + {{16{imm[15]}}, imm};
        mis = mis_of(sz, ea[1:0]);
        chk("R1 mem_addr", {2'b00, mem_addr}, {2'b00, ea[31:2]});
        chk("R2 misalign", {31'd0, misalign}, {31'd0, mis});
        if (st && !mis) begin
            chk("R3 strobes", {28'd0, mem_wstrb}, {28'd0, exp_strb(sz, ea[1:0], be)});
            chk("R4 write data", mem_wdata, exp_wdata(sz, sd));
        end else begin
            chk("R5 strobes off", {28'd0, mem_wstrb}, 32'd0);
        end
        @(negedge clk);
        // scramble request fields: the load must use its captured decode
        req_valid = 1'b0; req_size = 2'($urandom); req_zext = 1'($urandom);
        req_big_endian = 1'($urandom); base_addr = $urandom; imm_ofs = 16'($urandom);
        mem_rdata = rd;
        #1;
        chk("R5 idle strobes", {28'd0, mem_wstrb}, 32'd0);
        if (!st && !mis) begin
            chk("R6 ld_valid", {31'd0, ld_valid}, 32'd1);
            chk("R6/R7/R10 ld_result", ld_result, exp_load(sz, ea[1:0], be, zx, rd));
        end else begin
            chk("R8 ld_valid", {31'd0, ld_valid}, 32'd0);
            chk("R8 ld_result", ld_result, 32'd0);
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R9 reset ld_valid", {31'd0, ld_valid}, 32'd0);
        chk("R9 reset ld_result", ld_result, 32'd0);
        chk("R9 reset strobes", {28'd0, mem_wstrb}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R9 post-reset ld_valid", {31'd0, ld_valid}, 32'd0);

        // directed: every size, offset, endianness, extension
        for (int sz = 0; sz < 4; sz++) begin
            for (int k = 0; k < 4; k++) begin
                for (int be = 0; be < 2; be++) begin
                    run_op(1'b1, 2'(sz), 1'b0, 1'(be), 32'h0000_1000 + 32'(k), 16'd0,
                           32'hA1B2_C3D4, 32'd0);
                    run_op(1'b0, 2'(sz), 1'b0, 1'(be), 32'h0000_2000 + 32'(k), 16'd0,
                           32'd0, 32'h80FF_7F01);
                    run_op(1'b0, 2'(sz), 1'b1, 1'(be), 32'h0000_2000 + 32'(k), 16'd0,
                           32'd0, 32'h80FF_7F01);
                    run_op(1'b0, 2'(sz), 1'b0, 1'(be), 32'h0000_2000 + 32'(k), 16'd0,
                           32'd0, 32'h7F80_01FE);
                end
            end
        end
        // negative displacement crossing a word boundary
        run_op(1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_1000, 16'hFFFF, 32'd0, 32'hF0E0_D0C0);
        run_op(1'b1, 2'd1, 1'b0, 1'b1, 32'h0000_1000, 16'hFFFE, 32'h0000_BEEF, 32'd0);
        run_op(1'b0, 2'd2, 1'b0, 1'b0, 32'h0000_0003, 16'h8001, 32'd0, 32'h1234_5678);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            run_op(1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                   $urandom, 16'($urandom), $urandom, $urandom);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule